// File: doc/BRIEF.md
# Dual-Port Address-Collision Busy Arbiter

This block sits beside a two-port memory and watches the enable and address of each port. When both ports are enabled on the same location at once, it decides which port keeps its access and raises an active-low busy flag toward the other one. In master mode the flag is driven out and the losing port's write strobe is suppressed. In slave mode the arbitration result is not used. The busy pins of each port become inputs, and a low level on them only blocks that port's writes. This lets several devices share one master's decision.

The port that has held its enable on its current address longest wins. The block tracks this with a registered per-port flag. That flag is set once a port has been enabled on an unchanged address for at least one sampled cycle. If both ports arrive in the same cycle, the left port wins, so the outcome is always deterministic. Reads and writes are not distinguished by the arbitration. All outputs are registered and reflect the inputs sampled at the previous rising edge.

Top module: `dp_collision_arb`

## Requirements
- R1: While rst_ni is low, both busy outputs are high (inactive) and both write strobes are low.
- R2: When either enable is high or the two addresses differ, both busy outputs are high one cycle later.
- R3: When both ports are enabled on the same address and one port was already enabled on that address in the previous cycle while the other was not, the newly arrived port sees busy low one cycle later.
- R4: When both ports become enabled on an equal address in the same cycle, the right port receives busy. This includes the case where both move together to a new equal address, and the case of the all-ones address.
- R5: The two busy outputs are never low at the same time.
- R6: The busy result does not depend on the write requests of either port.
- R7: In master mode, a port whose busy output is low has its write strobe low, even when it requests a write. The winning port's write passes.
- R8: Once decided, the winner is kept for as long as both ports stay enabled on the same unchanged address.
- R9: Busy and the write block are released one cycle after the addresses stop matching or an enable goes high.
- R10: In slave mode (master_i low), both busy outputs stay high. A port's write strobe is then blocked exactly when its busy input is low.
- R11: Without contention, a port's write strobe equals its write request while it is enabled, and is low otherwise. The strobe appears one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = master (busy driven), 0 = slave (busy sensed) |
| l_en_ni | input | 1 | Left port enable, active low |
| l_addr_i | input | ADDR_W | Left port address |
| l_wr_i | input | 1 | Left port write request |
| l_busy_i | input | 1 | Left busy input, slave mode, active low |
| l_busy_no | output | 1 | Left busy output, active low |
| l_we_o | output | 1 | Left gated write strobe |
| r_en_ni | input | 1 | Right port enable, active low |
| r_addr_i | input | ADDR_W | Right port address |
| r_wr_i | input | 1 | Right port write request |
| r_busy_i | input | 1 | Right busy input, slave mode, active low |
| r_busy_no | output | 1 | Right busy output, active low |
| r_we_o | output | 1 | Right gated write strobe |

## Verification
The arbitration is driven in several ways:
- The left port arrives first, the right port arrives first, and both arrive together. This separates arrival-order tracking from the tie rule.
- Both ports jump together to a new equal address, which shows that a held winner is not carried onto a fresh collision.
- The write requests are swapped under a standing collision, which shows that reads and writes do not steer the result.
- Enables drop and addresses diverge to show when the block releases.
- Slave rows pull each busy input low in turn, which shows that only the sensed pin blocks writes.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    SIDE_L = 1'b0,
    SIDE_R = 1'b1
  } side_e;
  localparam int unsigned NPORT = 2;
endpackage

// File: rtl/arb_port_track.sv
module arb_port_track #(
  parameter int unsigned ADDR_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              active_o,
  output logic              settled_o
);
  logic              act_q;
  logic [ADDR_W-1:0] addr_q;

  assign active_o  = ~en_ni;
  // enabled now and was enabled on the same address at the previous edge
  assign settled_o = active_o & act_q & (addr_i == addr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      act_q  <= active_o;
      addr_q <= addr_i;
    end
  end
endmodule

// File: rtl/arb_judge.sv
module arb_judge
  import arb_pkg::*;
#(
  parameter int unsigned ADDR_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_act_i,
  input  logic              l_set_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic              r_act_i,
  input  logic              r_set_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  output logic              l_lose_o,
  output logic              r_lose_o
);
  logic  match;
  logic  hold;
  logic  coll_q;
  side_e win_q, win_d;

  assign match = l_act_i & r_act_i & (l_addr_i == r_addr_i);
  // same collision as last cycle: both sides unchanged
  assign hold  = coll_q & l_set_i & r_set_i;

  always_comb begin
    if (hold)                    win_d = win_q;
    else if (r_set_i & ~l_set_i) win_d = SIDE_R;
    else                         win_d = SIDE_L;  // left first, or tie
  end

  assign l_lose_o = match & (win_d == SIDE_R);
  assign r_lose_o = match & (win_d == SIDE_L);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coll_q <= 1'b0;
      win_q  <= SIDE_L;
    end else begin
      coll_q <= match;
      win_q  <= win_d;
    end
  end
endmodule

// File: rtl/arb_wr_gate.sv
module arb_wr_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic master_i,
  input  logic active_i,
  input  logic wr_i,
  input  logic lose_i,
  input  logic busy_i,
  output logic busy_no,
  output logic we_o
);
  logic block;

  assign block = master_i ? lose_i : ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_no <= 1'b1;
      we_o    <= 1'b0;
    end else begin
      busy_no <= ~(master_i & lose_i);
      we_o    <= active_i & wr_i & ~block;
    end
  end
endmodule

// File: rtl/dp_collision_arb.sv
module dp_collision_arb
  import arb_pkg::*;
#(
  parameter int unsigned ADDR_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              l_en_ni,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic              l_wr_i,
  input  logic              l_busy_i,
  output logic              l_busy_no,
  output logic              l_we_o,
  input  logic              r_en_ni,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic              r_wr_i,
  input  logic              r_busy_i,
  output logic              r_busy_no,
  output logic              r_we_o
);
  logic [ADDR_W-1:0] addr   [NPORT];
  logic [NPORT-1:0]  en_n, wr, bsy_in, act, setl, lose, bsy_out, we;

  assign addr[0] = l_addr_i;
  assign addr[1] = r_addr_i;
  assign en_n    = {r_en_ni, l_en_ni};
  assign wr      = {r_wr_i, l_wr_i};
  assign bsy_in  = {r_busy_i, l_busy_i};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    arb_port_track #(.ADDR_W(ADDR_W)) u_trk (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_ni    (en_n[p]),
      .addr_i   (addr[p]),
      .active_o (act[p]),
      .settled_o(setl[p])
    );
    arb_wr_gate u_gate (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .master_i(master_i),
      .active_i(act[p]),
      .wr_i    (wr[p]),
      .lose_i  (lose[p]),
      .busy_i  (bsy_in[p]),
      .busy_no (bsy_out[p]),
      .we_o    (we[p])
    );
  end

  arb_judge #(.ADDR_W(ADDR_W)) u_judge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .l_act_i (act[0]),
    .l_set_i (setl[0]),
    .l_addr_i(addr[0]),
    .r_act_i (act[1]),
    .r_set_i (setl[1]),
    .r_addr_i(addr[1]),
    .l_lose_o(lose[0]),
    .r_lose_o(lose[1])
  );

  assign l_busy_no = bsy_out[0];
  assign r_busy_no = bsy_out[1];
  assign l_we_o    = we[0];
  assign r_we_o    = we[1];
endmodule

// File: rtl/dp_collision_arb_chk.sv
module dp_collision_arb_chk #(
  parameter int unsigned ADDR_W = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              master_i,
  input logic              l_en_ni,
  input logic [ADDR_W-1:0] l_addr_i,
  input logic              l_wr_i,
  input logic              l_busy_i,
  input logic              l_busy_no,
  input logic              l_we_o,
  input logic              r_en_ni,
  input logic [ADDR_W-1:0] r_addr_i,
  input logic              r_wr_i,
  input logic              r_busy_i,
  input logic              r_busy_no,
  input logic              r_we_o
);
  assert_never_both_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!l_busy_no && !r_busy_no));

  assert_no_match_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_en_ni || r_en_ni || (l_addr_i != r_addr_i)) |=> (l_busy_no && r_busy_no));

  assert_l_busy_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !l_busy_no |-> !l_we_o);

  assert_r_busy_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !r_busy_no |-> !r_we_o);

  assert_slave_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |=> (l_busy_no && r_busy_no));

  assert_l_slave_inhibit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!master_i && !l_busy_i) |=> !l_we_o);

  assert_r_slave_inhibit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!master_i && !r_busy_i) |=> !r_we_o);

  assert_l_no_req_no_we_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_wr_i || l_en_ni) |=> !l_we_o);

  assert_r_no_req_no_we_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!r_wr_i || r_en_ni) |=> !r_we_o);
endmodule

bind dp_collision_arb dp_collision_arb_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_dp_collision_arb.sv
`timescale 1ns/1ps
module sim_dp_collision_arb;
  localparam int unsigned AW = 14;
  localparam int NV = 16;
  // {m, l_en_n, l_addr[3:0], l_wr, l_busy_i, r_en_n, r_addr[3:0], r_wr, r_busy_i,
  //  exp l_busy_n, exp r_busy_n, exp l_we, exp r_we}
  localparam logic [18:0] VEC [NV] = '{
    19'b1_1_0000_1_1_1_0000_1_1_1100,
    19'b1_0_0101_1_1_1_0000_0_1_1110,
    19'b1_0_0101_0_1_0_0101_1_1_1000,
    19'b1_0_0101_1_1_0_0101_1_1_1010,
    19'b1_0_0101_1_1_0_0110_1_1_1111,
    19'b1_1_0101_0_1_1_0110_0_1_1100,
    19'b1_0_1001_0_1_0_1001_0_1_1000,
    19'b1_1_1001_0_1_0_1001_1_1_1101,
    19'b1_0_1001_1_1_0_1001_0_1_0100,
    19'b1_0_1001_0_1_0_1001_1_1_0101,
    19'b1_0_0011_1_1_0_0011_1_1_1010,
    19'b1_0_0001_1_1_0_0010_1_1_1111,
    19'b0_0_0100_1_1_0_0100_1_1_1111,
    19'b0_0_0100_1_0_0_0100_1_1_1101,
    19'b0_0_0100_1_1_0_0100_1_0_1110,
    19'b1_1_0100_1_1_1_0100_1_1_1100
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, master_i = 1'b1;
  logic l_en_ni = 1'b1, l_wr_i = 1'b0, l_busy_i = 1'b1;
  logic r_en_ni = 1'b1, r_wr_i = 1'b0, r_busy_i = 1'b1;
  logic [AW-1:0] l_addr_i = '0, r_addr_i = '0;
  logic l_busy_no, l_we_o, r_busy_no, r_we_o;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  dp_collision_arb #(.ADDR_W(AW)) u0 (.*);

  function automatic string req_of(int i);
    case (i)
      0: return "R11";  1: return "R11";  2: return "R3";   3: return "R8";
      4: return "R9";   5: return "R2";   6: return "R4";   7: return "R9";
      8: return "R3";   9: return "R6";  10: return "R4";  11: return "R2";
      12: return "R10"; 13: return "R10"; 14: return "R10"; default: return "R7";
    endcase
  endfunction

  task automatic check(string req, logic [3:0] exp);
    logic [3:0] act;
    act = {l_busy_no, r_busy_no, l_we_o, r_we_o};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {lbusy_n,rbusy_n,lwe,rwe} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(logic [18:0] v);
    master_i = v[18];
    l_en_ni  = v[17]; l_addr_i = AW'(v[16:13]); l_wr_i = v[12]; l_busy_i = v[11];
    r_en_ni  = v[10]; r_addr_i = AW'(v[9:6]);   r_wr_i = v[5];  r_busy_i = v[4];
  endtask

  initial begin
    // R1: colliding inputs held during reset
    drive(19'b1_0_0111_1_1_0_0111_1_1_0000);
    repeat (3) @(negedge clk_i);
    check("R1", 4'b1100);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk_i);
      check(req_of(i), VEC[i][3:0]);
    end
    // R7: collision, left wins, right write blocked while left write passes
    drive(19'b1_0_1010_1_1_1_0000_1_1_0000);
    @(negedge clk_i);
    drive(19'b1_0_1010_1_1_0_1010_1_1_0000);
    @(negedge clk_i);
    check("R7", 4'b1010);
    // R1: asynchronous reset in the middle of a collision
    rst_ni = 1'b0;
    #1;
    check("R1", 4'b1100);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R4: simultaneous arrival on the all-ones address
    master_i = 1'b1;
    l_en_ni = 1'b0; l_addr_i = '1; l_wr_i = 1'b1; l_busy_i = 1'b1;
    r_en_ni = 1'b0; r_addr_i = '1; r_wr_i = 1'b1; r_busy_i = 1'b1;
    @(negedge clk_i);
    check("R4", 4'b1010);
    // R9: right drops its enable, release in the next cycle
    r_en_ni = 1'b1;
    @(negedge clk_i);
    check("R9", 4'b1110);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule